// File: doc/BRIEF.md
# Backlight Contrast PWM Generator

This block produces a pulse-width-modulated signal for dimming an LCD backlight or setting panel contrast. Software programs two registers over a simple write/read port. A control register selects a clock prescaler, an output polarity and an enable. A separate compare register sets the duty cycle.

The block divides its clock by 1, 2, 4 or 8 and counts the prescaled ticks in an 8-bit period counter. One period is 256 ticks. The output is in its active state while the counter is below the loaded compare value. A compare write is staged and takes effect at the next counter wrap, so a running waveform never carries a shortened pulse. Writing zero to the control register switches the output to its idle level, whatever the compare value holds. This is how a driver turns the backlight off.

Top module: `cpwm_top`

## Requirements
- R1: After reset the control register reads 0x00, the compare register reads 0xC8 and `pwm_out` is low.
- R2: Address 0 reads the control register in bits [3:0] with bits [7:4] reading zero, even if ones were written there. Address 1 reads the last value written to the compare register, including while a change is still pending.
- R3: While enabled, one period lasts 256 prescaled ticks and the output is active for compare × divide clock cycles of each period.
- R4: Control bits [1:0] select the clock divide: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R5: A compare value of 0x00 keeps the output inactive for the whole period. A value of 0xFF makes it active for 255 of every 256 ticks.
- R6: Control bit 2 is the polarity. When 0, the active level is high. When 1, the active level is low, so the waveform is the exact complement.
- R7: When control bit 3 (enable) is 0, `pwm_out` stays at its inactive level: low when bit 2 is 0 and high when bit 2 is 1. This holds for any compare value.
- R8: A compare write made while enabled does not change the period in progress. The new value governs the period that starts after the next wrap.
- R9: While disabled, the period counter is held at zero and the latest compare value is loaded. The first pulse after enable therefore lasts compare × divide cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select: 0 control, 1 compare |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench uses the default parameters: an 8-bit period counter and a 2-bit prescaler select. With these defaults the longest period is 2048 cycles, so every divide setting can be measured over whole periods within the run. The same holds for both compare extremes, 0x00 and 0xFF, and for both polarities. Because the period is only 256 ticks at divide-by-one, a compare write can be placed in the middle of a live pulse. The bench then shows that this pulse keeps its old length and the next pulse takes the new one.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    parameter int CNT_W  = 8;
    parameter int SEL_W  = 2;
    parameter int DATA_W = 8;

    localparam int CTRL_W = SEL_W + 2;
    localparam int PRE_W  = (2 ** SEL_W) - 1;

    localparam logic [CNT_W-1:0] CMP_RESET = CNT_W'(8'hC8);

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_CMP  = 1'b1
    } reg_addr_e;

    // Field layout, MSB first: enable, invert, divide select
    typedef struct packed {
        logic             en;
        logic             inv;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    // Terminal count of the prescaler for divide 2**sel
    function automatic logic [PRE_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] span;
        span      = '0;
        span[sel] = 1'b1;
        span      = span - 1'b1;
        return span[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp_staged,
    output logic [DATA_W-1:0] rdata
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= CMP_RESET;
        end else if (wr_en) begin
            if (reg_addr_e'(addr) == ADDR_CTRL)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            else
                cmp_q  <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        if (reg_addr_e'(addr) == ADDR_CTRL)
            rdata = DATA_W'(ctrl_q);
        else
            rdata = DATA_W'(cmp_q);
    end

    assign ctrl       = ctrl_q;
    assign cmp_staged = cmp_q;

    // R2
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmp_q) && $stable(ctrl_q));

endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = div_limit(div_sel);
    // >= so that a smaller divide chosen mid-count still terminates at once
    assign tick  = en && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !en || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R4
    div8_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (en && div_sel == SEL_W'(3) && tick) |=> !tick);

    // R4
    div1_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && div_sel == '0) |-> tick);

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_staged,
    output logic             active
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_live_q;
    logic             wrap;

    assign wrap = tick && (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmp_live_q <= CMP_RESET;
        end else if (!en) begin
            cnt_q      <= '0;
            cmp_live_q <= cmp_staged;
        end else begin
            if (tick)
                cnt_q <= cnt_q + 1'b1;
            if (wrap)
                cmp_live_q <= cmp_staged;
        end
    end

    assign active = cnt_q < cmp_live_q;

    // R8
    cmp_only_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(cmp_live_q));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0);

    // R5
    zero_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_live_q == '0) |-> !active);

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
    import cpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_staged;
    logic             tick;
    logic             active;
    logic             out_q;

    cpwm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ctrl       (ctrl),
        .cmp_staged (cmp_staged),
        .rdata      (reg_rdata)
    );

    cpwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.en),
        .div_sel (ctrl.div_sel),
        .tick    (tick)
    );

    cpwm_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl.en),
        .tick       (tick),
        .cmp_staged (cmp_staged),
        .active     (active)
    );

    // Registered output keeps the pin free of compare glitches
    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else if (!ctrl.en)
            out_q <= ctrl.inv;
        else
            out_q <= active ^ ctrl.inv;
    end

    assign pwm_out = out_q;

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !reg_wr) |=> pwm_out == ctrl.inv);

endmodule

// File: tb/cpwm_top_tb.sv
`timescale 1ns/1ps
module cpwm_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cpwm_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic count_high(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    // Run with ctrl and compare, let it settle, measure one whole period
    task automatic duty(input string req, input logic [7:0] ctl, input logic [7:0] cmp);
        int div, n, exp;
        div = 1 << ctl[1:0];
        wr(1'b0, 8'h00);
        wr(1'b1, cmp);
        wr(1'b0, ctl);
        repeat (2 * 256 * div + 4) @(negedge clk);
        count_high(256 * div, n);
        exp = cmp * div;
        if (ctl[2]) exp = 256 * div - exp;
        check(req, n, exp);
    endtask

    task automatic t_reset();
        int v;
        rd(1'b0, v); check("R1 ctrl", v, 0);
        rd(1'b1, v); check("R1 cmp", v, 8'hC8);
        check("R1 out", pwm_out, 0);
    endtask

    task automatic t_readback();
        int v;
        wr(1'b0, 8'hF6);
        rd(1'b0, v); check("R2 ctrl upper zero", v, 8'h06);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h5A);
        rd(1'b1, v); check("R2 cmp", v, 8'h5A);
    endtask

    task automatic t_duty();
        duty("R3 div1 0x40",  8'h08, 8'h40);
        duty("R4 div2 0x30",  8'h09, 8'h30);
        duty("R4 div4 0x81",  8'h0A, 8'h81);
        duty("R4 div8 0xC8",  8'h0B, 8'hC8);
        duty("R5 cmp 0x00",   8'h08, 8'h00);
        duty("R5 cmp 0xFF",   8'h08, 8'hFF);
        duty("R6 inverted",   8'h0C, 8'h40);
        duty("R6 inv div2",   8'h0D, 8'hFF);
    endtask

    task automatic t_disable();
        int n;
        duty("R3 pre-disable", 8'h08, 8'hFF);
        wr(1'b0, 8'h00);
        count_high(512, n); check("R7 off low", n, 0);
        wr(1'b0, 8'h04);
        count_high(512, n); check("R7 off inv high", n, 512);
        // R9: compare written while disabled governs first pulse
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h09);
        count_high(128, n); check("R9 first pulse", n, 32);
    endtask

    task automatic t_defer();
        int n, guard;
        duty("R3 pre-defer", 8'h08, 8'h80);
        guard = 0;
        do begin @(negedge clk); guard++; end while (pwm_out && guard < 1000);
        do begin @(negedge clk); guard++; end while (!pwm_out && guard < 1000);
        n = 1;
        forever begin
            @(negedge clk);
            if (n == 64) begin reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h20; end
            else reg_wr = 1'b0;
            if (!pwm_out || n > 300) break;
            n++;
        end
        reg_wr = 1'b0;
        check("R8 running pulse kept", n, 128);
        guard = 0;
        do begin @(negedge clk); guard++; end while (!pwm_out && guard < 1000);
        n = 1;
        forever begin
            @(negedge clk);
            if (!pwm_out || n > 300) break;
            n++;
        end
        check("R8 next pulse new", n, 32);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_duty();
        t_disable();
        t_defer();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule